// File: doc/BRIEF.md
# Quad Tapped Delay Line

This block holds four independent one-bit delay channels that all run on the system clock. Each channel copies its input to its output without inversion. The copy is delayed by a fixed two-cycle inherent latency plus a programmable number of step delays, where one step is one clock cycle. The step count is the channel's tap address, from 0 to 15. Each channel registers its input and then shifts it through a chain of fifteen step stages. A multiplexer picks the stage named by the address, and an output register drives the pin. Rising and falling edges are therefore delayed by the same amount.

Each channel also has an enable. When the enable is low, the channel's output-enable falls and its data output is held low, which models a released (high-impedance) pin without any internal tristate buffer. The chain keeps shifting while the channel is disabled. The tap addresses and enables come from an external programming port, which is not part of this block.

The tap switches at once when the address changes. A new address is therefore only glitch-free once the whole chain holds one value. A per-channel settled flag reports this: it is set after the input has stayed unchanged for fifteen consecutive clock edges.

Top module: `tap_delay_quad`

## Requirements
- R1: While reset is high, and on the first cycle after a reset edge, every bit of `dout`, `dout_oe` and `settled` is 0.
- R2: With address 0 and the channel enabled, the value on `din[c]` at clock edge k appears on `dout[c]` after edge k+1. This is a total delay of 2 cycles.
- R3: For any address A from 0 to 15, the value on `din[c]` at edge k appears on `dout[c]` after edge k+1+A. This is a delay of 2+A cycles.
- R4: The output is never inverted, and a pulse of any width, high or low, comes out with its width unchanged.
- R5: Each channel uses only its own input, its own enable and its own address, `tap_sel[c*4+3 : c*4]`. Other channels' settings do not change its output.
- R6: `dout_oe[c]` takes the value `chan_en[c]` sampled at the previous edge. While `dout_oe[c]` is 0, `dout[c]` is 0.
- R7: The chain keeps shifting while the channel is disabled. On the first enabled cycle, the output already shows the input delayed by 2+A cycles.
- R8: `settled[c]` is 1 once `din[c]` has matched the previously registered input value on 15 consecutive edges. It is 0 after any edge at which `din[c]` differs from that value. At reset the registered input is 0 and the run count is 0.
- R9: An address change takes effect on the edge at which it is sampled, with no settling delay. The output after that edge shows the newly selected tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one step equals one cycle |
| rst | input | 1 | Synchronous active-high reset |
| din | input | NCH | One data input per channel |
| tap_sel | input | NCH*AW | Per-channel tap address; channel c uses bits c*AW+AW-1 down to c*AW |
| chan_en | input | NCH | Per-channel enable; low releases the output |
| dout | output | NCH | Delayed data per channel; 0 while disabled |
| dout_oe | output | NCH | Output-enable per channel (models the tristate control) |
| settled | output | NCH | Chain holds a uniform value; safe to re-address |

## Verification
The hardest cases to reach are those where the output depends on chain contents that built up while the tap or the enable was elsewhere. These are a channel re-enabled in the middle of traffic, and an address changed on every cycle so that every tap is read at a different depth. The stimulus disables channels while pseudo-random data flows and then re-enables them. It also steps the addresses on every cycle while the inputs keep changing. A reference model in the bench keeps a per-cycle history of the inputs and predicts each output from it. The settled flag is driven to both edges by holding inputs idle for more than fifteen cycles and then toggling a single channel.

// File: rtl/tdq_pkg.sv
package tdq_pkg;

    // Registered pin pair of one channel: data plus its output-enable
    typedef struct packed {
        logic data;
        logic oe;
    } tdq_pin_t;

    // Number of step stages for an address width (all codes except zero)
    function automatic int unsigned step_count(input int unsigned aw);
        return (1 << aw) - 1;
    endfunction

    // Width of a counter able to reach n
    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tdq_chain.sv
module tdq_chain #(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din,
    input  logic [AW-1:0] sel,
    output logic          head,
    output logic          tap_out
);
    localparam int unsigned NSTEP = tdq_pkg::step_count(AW);
    localparam int unsigned NTAP  = NSTEP + 1;

    logic             in_q;
    logic [NSTEP-1:0] stage;
    logic [NTAP-1:0]  taps;

    always_ff @(posedge clk) begin
        if (rst) in_q <= 1'b0;
        else     in_q <= din;
    end

    for (genvar i = 0; i < NSTEP; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= 1'b0;
                else     stage[i] <= in_q;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= 1'b0;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign taps    = {stage, in_q};
    assign tap_out = taps[sel];
    assign head    = in_q;

endmodule

// File: rtl/tdq_settle.sv
module tdq_settle #(
    parameter int unsigned AW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic head,
    output logic settled
);
    localparam int unsigned NSTEP = tdq_pkg::step_count(AW);
    localparam int unsigned CW    = tdq_pkg::cnt_width(NSTEP);
    localparam logic [CW-1:0] RUN_MAX = CW'(NSTEP);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)                 run_cnt <= '0;
        else if (din != head)    run_cnt <= '0;
        else if (run_cnt != RUN_MAX) run_cnt <= run_cnt + 1'b1;
    end

    assign settled = (run_cnt == RUN_MAX);

endmodule

// File: rtl/tdq_out.sv
module tdq_out (
    input  logic clk,
    input  logic rst,
    input  logic tap,
    input  logic en,
    output logic data,
    output logic oe
);
    tdq_pkg::tdq_pin_t pin_q, pin_d;

    always_comb begin
        pin_d.oe   = en;
        pin_d.data = en & tap;
    end

    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= pin_d;
    end

    assign data = pin_q.data;
    assign oe   = pin_q.oe;

endmodule

// File: rtl/tap_delay_quad.sv
module tap_delay_quad #(
    parameter int unsigned NCH = 4,
    parameter int unsigned AW  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   din,
    input  logic [NCH*AW-1:0] tap_sel,
    input  logic [NCH-1:0]   chan_en,
    output logic [NCH-1:0]   dout,
    output logic [NCH-1:0]   dout_oe,
    output logic [NCH-1:0]   settled
);
    logic [NCH-1:0] head;
    logic [NCH-1:0] tap;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tdq_chain #(.AW(AW)) u_chain (
            .clk    (clk),
            .rst    (rst),
            .din    (din[c]),
            .sel    (tap_sel[c*AW +: AW]),
            .head   (head[c]),
            .tap_out(tap[c])
        );

        tdq_settle #(.AW(AW)) u_settle (
            .clk    (clk),
            .rst    (rst),
            .din    (din[c]),
            .head   (head[c]),
            .settled(settled[c])
        );

        tdq_out u_out (
            .clk (clk),
            .rst (rst),
            .tap (tap[c]),
            .en  (chan_en[c]),
            .data(dout[c]),
            .oe  (dout_oe[c])
        );
    end

endmodule

// File: rtl/tdq_checks.sv
module tdq_checks #(
    parameter int unsigned NCH = 4,
    parameter int unsigned AW  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    din,
    input logic [NCH*AW-1:0] tap_sel,
    input logic [NCH-1:0]    chan_en,
    input logic [NCH-1:0]    dout,
    input logic [NCH-1:0]    dout_oe,
    input logic [NCH-1:0]    settled
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dout_oe == '0 && settled == '0 && dout == '0));

    p_oe_follows_r6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> dout_oe == $past(chan_en));

    p_off_is_low_r6: assert property (@(posedge clk) disable iff (rst)
        (dout & ~dout_oe) == '0);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        p_addr0_latency_r2: assert property (@(posedge clk) disable iff (rst)
            ($past(rst) == 1'b0 && chan_en[c] && tap_sel[c*AW +: AW] == '0)
            |=> dout[c] == $past(din[c], 2));

        p_settle_drop_r8: assert property (@(posedge clk) disable iff (rst)
            ($past(rst) == 1'b0 && din[c] != $past(din[c])) |=> !settled[c]);

        p_settle_hold_r8: assert property (@(posedge clk) disable iff (rst)
            ($past(rst) == 1'b0 && settled[c] && din[c] == $past(din[c]))
            |=> settled[c]);
    end

endmodule

bind tap_delay_quad tdq_checks #(.NCH(NCH), .AW(AW)) u_checks (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .tap_sel(tap_sel),
    .chan_en(chan_en),
    .dout   (dout),
    .dout_oe(dout_oe),
    .settled(settled)
);

// File: tb/tap_delay_quad_test.sv
`timescale 1ns/1ps
module tap_delay_quad_test;
    localparam int NCH = 4;
    localparam int AW  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NCH-1:0]   din = '0;
    logic [NCH*AW-1:0] tap_sel = '0;
    logic [NCH-1:0]   chan_en = '0;
    logic [NCH-1:0]   dout, dout_oe, settled;

    tap_delay_quad #(.NCH(NCH), .AW(AW)) uut (
        .clk(clk), .rst(rst), .din(din), .tap_sel(tap_sel),
        .chan_en(chan_en), .dout(dout), .dout_oe(dout_oe), .settled(settled)
    );

    always #2.5 clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";
    logic [15:0] lfsr = 16'hACE1;

    // reference model: history of sampled inputs, newest first
    logic [NCH-1:0] hist [0:15];
    int             run  [NCH];
    logic [NCH-1:0] exp_dout = '0, exp_oe = '0, exp_set = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) hist[i] = '0;
            for (int c = 0; c < NCH; c++) run[c] = 0;
            exp_dout = '0; exp_oe = '0; exp_set = '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                int a;
                a = int'(tap_sel[c*AW +: AW]);
                exp_dout[c] = chan_en[c] ? hist[a][c] : 1'b0;
                exp_oe[c]   = chan_en[c];
                if (din[c] != hist[0][c]) run[c] = 0;
                else if (run[c] < 15) run[c] = run[c] + 1;
                exp_set[c] = (run[c] >= 15);
            end
            for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = din;
        end
        started = 1'b1;
    end

    task automatic check(input string what, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check("dout",    dout,    exp_dout);
            check("dout_oe", dout_oe, exp_oe);
            check("settled", settled, exp_set);
        end
    end

    task automatic step_rand(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            din  = lfsr[NCH-1:0];
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        hold(4);
        tag = "R1";
        rst = 1'b0;
        hold(1);
        rst = 1'b1;
        hold(2);
        rst = 1'b0;
        // R2: all taps at address 0
        tag = "R2";
        chan_en = '1;
        tap_sel = '0;
        step_rand(30);
        // R3: sweep channel 0 through every address
        tag = "R3";
        for (int a = 0; a < 16; a++) begin
            tap_sel = {4'd3, 4'd7, 4'd15, 4'(a)};
            step_rand(22);
        end
        // R4: isolated high and low pulses of several widths
        tag = "R4";
        tap_sel = {4'd15, 4'd9, 4'd4, 4'd1};
        for (int w = 1; w < 6; w++) begin
            din = '0; hold(20);
            din = '1; hold(w);
            din = '0; hold(20);
            din = '1; hold(20);
            din = '0; hold(w);
            din = '1; hold(20);
        end
        // R5: distinct pattern per channel
        tag = "R5";
        tap_sel = {4'd2, 4'd11, 4'd0, 4'd6};
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            din = {(i % 3 == 0), 1'b1, lfsr[0], din[0] ^ 1'b1};
        end
        // R6: enables toggled during traffic
        tag = "R6";
        chan_en = 4'b0101;
        step_rand(12);
        chan_en = 4'b1010;
        step_rand(12);
        // R7: all disabled while data flows, then re-enabled
        tag = "R7";
        tap_sel = {4'd15, 4'd8, 4'd5, 4'd12};
        chan_en = '0;
        step_rand(25);
        chan_en = '1;
        step_rand(25);
        // R8: settle flag rise and fall
        tag = "R8";
        din = 4'b0110;
        hold(20);
        din = 4'b0111;
        hold(10);
        din = 4'b0110;
        hold(18);
        // R9: address changed on every cycle under traffic
        tag = "R9";
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            din = lfsr[3:0];
            tap_sel = {4'(i % 16), 4'((i * 7) % 16), 4'(15 - (i % 16)), lfsr[11:8]};
        end
        hold(20);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule